// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block drives a single-lane SPI NOR flash from a short program held in registers. Software fills two opcode slots, an address-phase configuration, a 32-bit address and an instruction list of up to eight 3-bit codes. It then writes the start bit. The engine walks the list in order. For each entry it shifts out the selected opcode or address part, MSB first, with its own bit count. An entry can also release chip select when its phase is done. The list ends on a stop code.

Each phase carries its own chip-select release flag. A write-enable opcode and a sector-erase opcode with its address can therefore run from a single start, with the flash seeing two separate chip-select frames. After a release, the engine holds chip select high for a guaranteed gap before the next frame. Software polls an idle bit in the status register. Configuration writes are locked out while a program runs.

Top module: `sflash_seq_engine`

## Requirements
- R1: Register map at word addresses 0..6. Addresses 0 and 1 are opcode slots 1 and 2: opcode [7:0], bit count [12:8], pad count [17:16], release flag [20]. Address 2 is the address-phase config: first-part bit count [4:0], second-part bit count [12:8], release-after-second-part [16]. Address 3 is the 32-bit address. Address 4 is the instruction list, entry i at bits [3i+2:3i]. Address 5 is the sequence config: single-pad [0], read-not-write [1], release-at-end [2], start [3]. Every field reads back as written, the start bit reads 0, and all other bits read 0.
- R2: Status register (address 6) bit 4 reads 1 while idle and 0 from the clock after an accepted start until the sequence has ended. SCLK and MOSI stay low while idle.
- R3: The engine executes list entries in stored order. Code 1 sends slot 1, code 2 sends slot 2, code 3 sends the first address part, code 4 sends the second address part. Code 0 ends the sequence, and codes 5 to 7 end it the same way.
- R4: An opcode phase with bit count N sends the opcode MSB first. When N is below 8, only its top N bits are sent. Bits beyond 8 are sent as 0.
- R5: The first address part with count N sends address bits [15+N:16] MSB first, so 8 gives bits 23:16 and 16 gives bits 31:16. The second address part with count N sends bits [N-1:0].
- R6: SCLK is the clock divided by 4 in SPI mode 0. Each bit lasts 4 clocks: 2 with SCLK low, then 2 high. MOSI changes only while SCLK is low. One clock with SCLK low separates consecutive phases. MOSI is 0 outside bits.
- R7: A phase whose release flag is set drives CS_n high on the clock after its last bit. CS_n then stays high for at least 9 clocks, which is more than two SCLK periods, before the next phase pulls it low.
- R8: When release-at-end is set, CS_n goes high one clock after the end of the sequence. When it is clear, CS_n stays low, and the next started sequence continues in the same frame without a gap.
- R9: Writes to addresses 0 to 5, including the start bit, are ignored while the engine is busy.
- R10: A list with no ending code runs all 8 entries and then returns to idle.
- R11: A bit count of 0 skips the entry: no bits are sent and its release flag has no effect. A count above 16 is treated as 16.
- R12: After reset, CS_n is high, SCLK and MOSI are low, every register reads 0 and the status register reads 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The bench builds the engine with its defaults: an 8-entry list, an SCLK half period of 2 clocks and an 8-clock release gap. With these values the full-list path without a stop code finishes in a few hundred clocks. The 9-clock chip-select gap also appears in every write-enable then erase program, so the gap stall, the skip of zero-count entries and the lockout of busy writes all fall inside short runs. The 16-bit saturation of oversized counts is reachable with the 5-bit count fields.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;
    localparam int CODE_W  = 3;
    localparam int CYC_W   = 5;
    localparam int PH_BITS = 16;

    localparam logic [2:0] A_SLOT1  = 3'd0;
    localparam logic [2:0] A_SLOT2  = 3'd1;
    localparam logic [2:0] A_ACFG   = 3'd2;
    localparam logic [2:0] A_ADDR   = 3'd3;
    localparam logic [2:0] A_LIST   = 3'd4;
    localparam logic [2:0] A_CFG    = 3'd5;
    localparam logic [2:0] A_STATUS = 3'd6;

    typedef enum logic [CODE_W-1:0] {
        INS_STOP = 3'd0,
        INS_CMD1 = 3'd1,
        INS_CMD2 = 3'd2,
        INS_ADD1 = 3'd3,
        INS_ADD2 = 3'd4
    } ins_e;

    typedef struct packed {
        logic             rel;
        logic [CYC_W-1:0] cyc;
        logic [7:0]       opc;
    } slot_t;

    typedef struct packed {
        logic             rel2;
        logic [CYC_W-1:0] cyc2;
        logic [CYC_W-1:0] cyc1;
    } acfg_t;
endpackage

// File: rtl/sfseq_regs.sv
module sfseq_regs
    import sfseq_pkg::*;
#(
    parameter int LIST_DEPTH = 8,
    localparam int LIST_W = LIST_DEPTH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    output logic              start,
    output slot_t             slot1,
    output slot_t             slot2,
    output acfg_t             acfg,
    output logic [31:0]       addr,
    output logic [LIST_W-1:0] list,
    output logic              rel_end
);
    typedef struct packed {
        slot_t             s1;
        slot_t             s2;
        logic [1:0]        pads1;
        logic [1:0]        pads2;
        acfg_t             ac;
        logic [31:0]       adr;
        logic [LIST_W-1:0] lst;
        logic              pad1;
        logic              rnw;
        logic              rel_end;
    } regs_t;

    regs_t r_d, r_q;

    function automatic logic [31:0] slot_word(slot_t s, logic [1:0] pads);
        return {11'd0, s.rel, 2'd0, pads, 3'd0, s.cyc, s.opc};
    endfunction

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (reg_we && !busy) begin
            case (reg_addr)
                A_SLOT1: begin
                    r_d.s1    = '{rel: reg_wdata[20], cyc: reg_wdata[12:8], opc: reg_wdata[7:0]};
                    r_d.pads1 = reg_wdata[17:16];
                end
                A_SLOT2: begin
                    r_d.s2    = '{rel: reg_wdata[20], cyc: reg_wdata[12:8], opc: reg_wdata[7:0]};
                    r_d.pads2 = reg_wdata[17:16];
                end
                A_ACFG: r_d.ac  = '{rel2: reg_wdata[16], cyc2: reg_wdata[12:8], cyc1: reg_wdata[4:0]};
                A_ADDR: r_d.adr = reg_wdata;
                A_LIST: r_d.lst = reg_wdata[LIST_W-1:0];
                A_CFG: begin
                    r_d.pad1    = reg_wdata[0];
                    r_d.rnw     = reg_wdata[1];
                    r_d.rel_end = reg_wdata[2];
                    start       = reg_wdata[3];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = 32'd0;
        case (reg_addr)
            A_SLOT1:  reg_rdata = slot_word(r_q.s1, r_q.pads1);
            A_SLOT2:  reg_rdata = slot_word(r_q.s2, r_q.pads2);
            A_ACFG:   reg_rdata = {15'd0, r_q.ac.rel2, 3'd0, r_q.ac.cyc2, 3'd0, r_q.ac.cyc1};
            A_ADDR:   reg_rdata = r_q.adr;
            A_LIST:   reg_rdata = {{(32-LIST_W){1'b0}}, r_q.lst};
            A_CFG:    reg_rdata = {29'd0, r_q.rel_end, r_q.rnw, r_q.pad1};
            A_STATUS: reg_rdata = {27'd0, !busy, 4'd0};
            default:  reg_rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign slot1   = r_q.s1;
    assign slot2   = r_q.s2;
    assign acfg    = r_q.ac;
    assign addr    = r_q.adr;
    assign list    = r_q.lst;
    assign rel_end = r_q.rel_end;
endmodule

// File: rtl/sfseq_sequencer.sv
module sfseq_sequencer
    import sfseq_pkg::*;
#(
    parameter int LIST_DEPTH = 8,
    localparam int LIST_W = LIST_DEPTH * CODE_W,
    localparam int IDX_W  = $clog2(LIST_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  slot_t              slot1,
    input  slot_t              slot2,
    input  acfg_t              acfg,
    input  logic [31:0]        addr,
    input  logic [LIST_W-1:0]  list,
    input  logic               rel_end_cfg,
    input  logic               done,
    input  logic               gap_busy,
    output logic               busy,
    output logic               load,
    output logic [PH_BITS-1:0] load_word,
    output logic [CYC_W-1:0]   load_bits,
    output logic               load_rel,
    output logic               end_rel
);
    typedef enum logic [1:0] {S_IDLE, S_DECODE, S_SHIFT} st_e;

    typedef struct packed {
        st_e              st;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;
    logic [CODE_W-1:0] code;
    logic              is_end;

    function automatic logic [CYC_W-1:0] sat_bits(logic [CYC_W-1:0] c);
        return (c > CYC_W'(PH_BITS)) ? CYC_W'(PH_BITS) : c;
    endfunction

    always_comb begin
        code = INS_STOP;
        for (int i = 0; i < LIST_DEPTH; i++) begin
            if (s_q.idx == IDX_W'(i)) code = list[i*CODE_W +: CODE_W];
        end
    end

    always_comb begin
        is_end    = 1'b0;
        load_word = '0;
        load_bits = '0;
        load_rel  = 1'b0;
        case (code)
            INS_CMD1: begin
                load_bits = sat_bits(slot1.cyc);
                load_word = {slot1.opc, 8'h00};
                load_rel  = slot1.rel;
            end
            INS_CMD2: begin
                load_bits = sat_bits(slot2.cyc);
                load_word = {slot2.opc, 8'h00};
                load_rel  = slot2.rel;
            end
            INS_ADD1: begin
                load_bits = sat_bits(acfg.cyc1);
                load_word = addr[31:16] << (CYC_W'(PH_BITS) - load_bits);
            end
            INS_ADD2: begin
                load_bits = sat_bits(acfg.cyc2);
                load_word = addr[15:0] << (CYC_W'(PH_BITS) - load_bits);
                load_rel  = acfg.rel2;
            end
            default: is_end = 1'b1;
        endcase
        if (s_q.idx == IDX_W'(LIST_DEPTH)) is_end = 1'b1;
    end

    always_comb begin
        s_d     = s_q;
        load    = 1'b0;
        end_rel = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.st  = S_DECODE;
                    s_d.idx = '0;
                end
            end
            S_DECODE: begin
                if (is_end) begin
                    end_rel = rel_end_cfg;
                    s_d.st  = S_IDLE;
                end else if (load_bits == '0) begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                end else if (!gap_busy) begin
                    load   = 1'b1;
                    s_d.st = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (done) begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                    s_d.st  = S_DECODE;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, idx: '0};
        else        s_q <= s_d;
    end

    assign busy = (s_q.st != S_IDLE);
endmodule

// File: rtl/sfseq_shifter.sv
module sfseq_shifter
    import sfseq_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int GAP_CLKS  = 8,
    localparam int PH_W  = $clog2(2 * SCLK_HALF),
    localparam int GAP_W = $clog2(GAP_CLKS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PH_BITS-1:0] load_word,
    input  logic [CYC_W-1:0]   load_bits,
    input  logic               load_rel,
    input  logic               end_rel,
    output logic               done,
    output logic               gap_busy,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * SCLK_HALF - 1);
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(SCLK_HALF - 1);

    typedef struct packed {
        logic               active;
        logic [PH_W-1:0]    ph;
        logic [CYC_W-1:0]   cnt;
        logic [PH_BITS-1:0] sh;
        logic               rel;
        logic               cs_n;
        logic               sclk;
        logic               mosi;
        logic [GAP_W-1:0]   gap;
    } sh_t;

    sh_t h_d, h_q;

    always_comb begin
        h_d  = h_q;
        done = h_q.active && (h_q.ph == PH_LAST) && (h_q.cnt == CYC_W'(1));
        if (h_q.gap != '0) h_d.gap = h_q.gap - GAP_W'(1);
        if (load) begin
            h_d.active = 1'b1;
            h_d.ph     = '0;
            h_d.cnt    = load_bits;
            h_d.mosi   = load_word[PH_BITS-1];
            h_d.sh     = load_word << 1;
            h_d.sclk   = 1'b0;
            h_d.cs_n   = 1'b0;
            h_d.rel    = load_rel;
        end else if (h_q.active) begin
            if (h_q.ph == PH_LAST) begin
                h_d.ph   = '0;
                h_d.sclk = 1'b0;
                if (h_q.cnt == CYC_W'(1)) begin
                    h_d.active = 1'b0;
                    h_d.mosi   = 1'b0;
                    if (h_q.rel) begin
                        h_d.cs_n = 1'b1;
                        h_d.gap  = GAP_W'(GAP_CLKS);
                    end
                end else begin
                    h_d.cnt  = h_q.cnt - CYC_W'(1);
                    h_d.mosi = h_q.sh[PH_BITS-1];
                    h_d.sh   = h_q.sh << 1;
                end
            end else begin
                h_d.ph   = h_q.ph + PH_W'(1);
                h_d.sclk = (h_q.ph >= PH_RISE);
            end
        end else if (end_rel && !h_q.cs_n) begin
            h_d.cs_n = 1'b1;
            h_d.gap  = GAP_W'(GAP_CLKS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q      <= '0;
            h_q.cs_n <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    assign gap_busy = (h_q.gap != '0);
    assign sclk     = h_q.sclk;
    assign mosi     = h_q.mosi;
    assign cs_n     = h_q.cs_n;
endmodule

// File: rtl/sflash_seq_engine.sv
module sflash_seq_engine
    import sfseq_pkg::*;
#(
    parameter int LIST_DEPTH = 8,
    parameter int SCLK_HALF  = 2,
    parameter int GAP_CLKS   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi
);
    localparam int LIST_W = LIST_DEPTH * CODE_W;

    logic               seq_busy;
    logic               start;
    slot_t              slot1, slot2;
    acfg_t              acfg;
    logic [31:0]        addr;
    logic [LIST_W-1:0]  list;
    logic               rel_end;
    logic               done, gap_busy, load, load_rel, end_rel;
    logic [PH_BITS-1:0] load_word;
    logic [CYC_W-1:0]   load_bits;

    sfseq_regs #(.LIST_DEPTH(LIST_DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(seq_busy),
        .start(start), .slot1(slot1), .slot2(slot2), .acfg(acfg),
        .addr(addr), .list(list), .rel_end(rel_end)
    );

    sfseq_sequencer #(.LIST_DEPTH(LIST_DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .slot1(slot1), .slot2(slot2),
        .acfg(acfg), .addr(addr), .list(list), .rel_end_cfg(rel_end),
        .done(done), .gap_busy(gap_busy), .busy(seq_busy), .load(load),
        .load_word(load_word), .load_bits(load_bits), .load_rel(load_rel),
        .end_rel(end_rel)
    );

    sfseq_shifter #(.SCLK_HALF(SCLK_HALF), .GAP_CLKS(GAP_CLKS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
        .load_bits(load_bits), .load_rel(load_rel), .end_rel(end_rel),
        .done(done), .gap_busy(gap_busy), .sclk(spi_sclk), .mosi(spi_mosi),
        .cs_n(spi_cs_n)
    );
endmodule

// File: rtl/sfseq_checker.sv
module sfseq_checker #(
    parameter int GAP_CLKS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic busy
);
    logic [4:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                hi_q <= 5'd31;
        else if (!cs_n)            hi_q <= 5'd0;
        else if (hi_q != 5'd31)    hi_q <= hi_q + 5'd1;
    end

    assert_sclk_inside_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    assert_mosi_steady_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    assert_sclk_high_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> sclk);

    assert_sclk_low_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |=> !sclk);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !mosi));

    assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_q >= 5'(GAP_CLKS + 1)));
endmodule

bind sflash_seq_engine sfseq_checker #(.GAP_CLKS(GAP_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .busy(seq_busy)
);

// File: tb/sflash_seq_engine_test.sv
`timescale 1ns/1ps
module sflash_seq_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi;

    sflash_seq_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
    );

    always #2 clk = ~clk;

    typedef struct { bit sclk; bit cs; bit mosi; bit idle; } exp_t;
    exp_t  q[$];
    int    nvec = 0, nfail = 0, cyc = 0, m_t = 0, rel_t = -1000;
    bit    cs_cur = 1'b1, last_idle = 1'b1, checking = 1'b0, finished = 1'b0;
    string cur_tag = "R12";
    logic [31:0] sh[0:5];

    always @(posedge clk) cyc++;

    function automatic int bits_of(int c);
        return (c > 16) ? 16 : c;
    endfunction

    function automatic void push(bit s, bit c, bit m, bit i);
        exp_t e;
        e.sclk = s; e.cs = c; e.mosi = m; e.idle = i;
        q.push_back(e);
        m_t++;
    endfunction

    function automatic void push_dec();
        push(1'b0, cs_cur, 1'b0, 1'b0);
    endfunction

    function automatic void seq_end();
        push_dec();
        if (sh[5][2] && !cs_cur) begin cs_cur = 1'b1; rel_t = m_t; end
    endfunction

    function automatic void run_model();
        bit ended = 1'b0;
        m_t = cyc + 1;
        for (int i = 0; i < 8; i++) begin
            int code = (sh[4] >> (3 * i)) & 7;
            int n = 0;
            logic [15:0] w = 16'd0;
            bit rel = 1'b0;
            if (code == 0 || code > 4) begin seq_end(); ended = 1'b1; break; end
            case (code)
                1: begin n = bits_of(sh[0][12:8]); w = {sh[0][7:0], 8'h00}; rel = sh[0][20]; end
                2: begin n = bits_of(sh[1][12:8]); w = {sh[1][7:0], 8'h00}; rel = sh[1][20]; end
                3: begin n = bits_of(sh[2][4:0]);  w = 16'(sh[3][31:16] << (16 - n)); end
                default: begin n = bits_of(sh[2][12:8]); w = 16'(sh[3][15:0] << (16 - n)); rel = sh[2][16]; end
            endcase
            if (n == 0) begin push_dec(); continue; end
            while (cs_cur && (m_t - rel_t < 8)) push_dec();
            push_dec();
            cs_cur = 1'b0;
            for (int b = 0; b < n; b++)
                for (int p = 0; p < 4; p++) push(p >= 2, 1'b0, w[15-b], 1'b0);
            if (rel) begin cs_cur = 1'b1; rel_t = m_t; end
        end
        if (!ended) seq_end();
    endfunction

    always @(negedge clk) begin
        if (checking && !finished) begin
            exp_t e;
            if (q.size() != 0) e = q.pop_front();
            else begin e.sclk = 1'b0; e.cs = cs_cur; e.mosi = 1'b0; e.idle = 1'b1; end
            nvec++;
            if (spi_sclk !== e.sclk || spi_cs_n !== e.cs || spi_mosi !== e.mosi) begin
                nfail++;
                $display("FAIL %s (R6 sclk, R7 cs_n) cycle %0d: got sclk=%b cs_n=%b mosi=%b, expected sclk=%b cs_n=%b mosi=%b",
                         cur_tag, cyc, spi_sclk, spi_cs_n, spi_mosi, e.sclk, e.cs, e.mosi);
            end
            last_idle = e.idle;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bit ok;
        @(negedge clk); #1;
        ok = (q.size() == 0) && last_idle;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (ok) begin
            case (a)
                3'd0, 3'd1: sh[a] = d & 32'h0013_1FFF;
                3'd2: sh[2] = d & 32'h0001_1F1F;
                3'd3: sh[3] = d;
                3'd4: sh[4] = d & 32'h00FF_FFFF;
                3'd5: sh[5] = d & 32'h0000_0007;
                default: ;
            endcase
            if (a == 3'd5 && d[3]) run_model();
        end
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk); #1;
        reg_addr = a;
        #1;
        if (a == 3'd6)     e = last_idle ? 32'h10 : 32'h0;
        else if (a == 3'd7) e = 32'h0;
        else               e = sh[a];
        nvec++;
        if (reg_rdata !== e) begin
            nfail++;
            $display("FAIL %s register %0d: got %h, expected %h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic wait_idle();
        int lim = 0;
        do begin @(negedge clk); #1; lim++; end
        while (!(q.size() == 0 && last_idle) && lim < 20000);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            nfail++;
            $display("FAIL R2 watchdog: got busy, expected idle before timeout");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) sh[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;

        // R12: reset values
        cur_tag = "R12";
        for (int i = 0; i < 8; i++) rd(3'(i), "R12");

        // R1: readback of every field, start reads 0
        cur_tag = "R1";
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'h0012_0A5C); wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hDEAD_BEEF); wr(3'd4, 32'hFF00_0000); wr(3'd5, 32'h0000_0003);
        for (int i = 0; i < 8; i++) rd(3'(i), "R1");

        // R3 R4 R5 R7: write-enable then erase, 24-bit address
        cur_tag = "R7";
        wr(3'd0, 32'h0010_0806); wr(3'd1, 32'h0000_08D8);
        wr(3'd2, 32'h0001_1008); wr(3'd3, 32'h12A5_C3F0);
        wr(3'd4, 32'h0000_08D1); wr(3'd5, 32'h0000_000F);
        rd(3'd6, "R2");
        wait_idle();
        rd(3'd6, "R2");

        // R5: 32-bit address mode, first part 16 bits
        cur_tag = "R5";
        wr(3'd2, 32'h0001_1010); wr(3'd3, 32'hF00D_BEEF);
        wr(3'd5, 32'h0000_000C);
        wait_idle();

        // R9: writes during a run are dropped
        cur_tag = "R9";
        wr(3'd5, 32'h0000_000C);
        wr(3'd0, 32'h0000_0333);
        wr(3'd5, 32'h0000_0008);
        wr(3'd3, 32'h0000_0000);
        wait_idle();
        rd(3'd0, "R9"); rd(3'd3, "R9"); rd(3'd5, "R9");
        repeat (20) @(negedge clk);

        // R10: eight entries without an ending code
        cur_tag = "R10";
        wr(3'd0, 32'h0000_02C3); wr(3'd4, 32'h0024_9249); wr(3'd5, 32'h0000_000C);
        wait_idle();

        // R3: order and an invalid code ends the list
        cur_tag = "R3";
        wr(3'd1, 32'h0010_089F); wr(3'd2, 32'h0000_0C08); wr(3'd3, 32'h0000_0F5A);
        wr(3'd4, 32'h0000_0A94); wr(3'd5, 32'h0000_000C);
        wait_idle();

        // R4 R11: zero count skips, oversize count saturates at 16
        cur_tag = "R11";
        wr(3'd0, 32'h0010_00FF); wr(3'd1, 32'h0000_14A5);
        wr(3'd4, 32'h0000_0011); wr(3'd5, 32'h0000_000C);
        wait_idle();
        cur_tag = "R4";
        wr(3'd1, 32'h0010_0581); wr(3'd4, 32'h0000_0002); wr(3'd5, 32'h0000_000C);
        wait_idle();

        // R8: no release at end keeps the frame open into the next run
        cur_tag = "R8";
        wr(3'd1, 32'h0000_083C); wr(3'd4, 32'h0000_0002); wr(3'd5, 32'h0000_0008);
        wait_idle();
        repeat (5) @(negedge clk);
        wr(3'd5, 32'h0000_000C);
        wait_idle();
        repeat (12) @(negedge clk);

        // R6: bit timing over a long mixed program
        cur_tag = "R6";
        wr(3'd0, 32'h0010_0866); wr(3'd1, 32'h0000_0899); wr(3'd2, 32'h0000_1010);
        wr(3'd3, 32'h5A5A_A5A5); wr(3'd4, 32'h0000_0919); wr(3'd5, 32'h0000_000C);
        wait_idle();
        rd(3'd6, "R2");
        repeat (10) @(negedge clk);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule